// File: doc/BRIEF.md
# Float immediate constant builder

This block produces floating-point register values from instruction immediates, so that constants reach a double-format register without a memory load. It serves two operations. A load takes a 16-bit immediate, treats it as the upper half of a single-precision pattern whose lower half is zero, and widens that pattern to double precision. A patch reads the current double value of the destination register, narrows it to single precision, replaces the lower 16 bits of the single pattern with a new immediate, and widens the result back to double.

A load followed by a patch on the same register therefore builds any single-precision constant, held in double format. The instruction decoder supplies the three raw immediate fields, the operation select and the current register value. The result comes out of a register one cycle later, with a valid strobe. The register file writes it back. Neither operation changes any floating-point status or exception flag, and the block has no flag outputs.

Top module: `fimm_builder`

## Requirements
- R1: The 16-bit immediate is the concatenation {fld_hi, fld_mid, fld_lo}. fld_hi (10 bits) is the most significant part and fld_lo (1 bit) is bit 0.
- R2: With op = 0 (load), the result is the double-precision widening of the single pattern {imm, 16'h0000}.
- R3: A load of 0x3F80 gives +1.0 (0x3FF0000000000000). A load of 0x0000 gives +0.0. The loads 0x8000, 0xBF80, 0xBFC0, 0x7FC0, 0x7F80, 0xFF80 and 0x3FFF give -0.0, -1.0, -1.5, the positive quiet NaN 0x7FF8000000000000, +infinity, -infinity and +1.9921875 (0x3FFFE00000000000).
- R4: Widening keeps the sign and adds 896 to a nonzero, non-all-ones single exponent. It places the 23-bit fraction in the top of the 52-bit fraction field. A single exponent of zero with a zero fraction gives a signed zero. A single exponent of all ones gives exponent 0x7FF with the fraction kept.
- R5: Widening normalizes a single subnormal (exponent zero, nonzero fraction). The leading one is shifted out and the exponent becomes 896 minus the number of leading zeros in the 23-bit fraction. For example, a patch of 0x0001 on +0.0 gives 0x36A0000000000000.
- R6: With op = 1 (patch), the result is the widening of the narrowed register value with its bits 15:0 replaced by imm. For example, 0x3FF0000000000000 patched with 0x8000 gives 0x3FF0100000000000.
- R7: Narrowing keeps the sign and the top 23 fraction bits, and drops the lower fraction bits. Double exponent 0 gives signed zero, and 0x7FF gives exponent all ones. Exponents 897..1150 are rebiased by subtracting 896. Exponents above 1150 give signed infinity. Exponents 874..896 give a single subnormal whose fraction is {1, top23} shifted right by 897 minus the exponent. Exponents below 874 give signed zero.
- R8: out_valid is high in exactly the cycle after one with in_valid high. out_value changes only after an accepted input and holds otherwise.
- R9: While rst is high, out_valid and out_value are cleared to zero.
- R10: A load ignores reg_value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 1 | 0 = load, 1 = patch low half |
| fld_hi | input | 10 | Upper immediate field |
| fld_mid | input | 5 | Middle immediate field |
| fld_lo | input | 1 | Lowest immediate bit |
| reg_value | input | 64 | Current double-format register value |
| out_valid | output | 1 | Result strobe |
| out_value | output | 64 | Double-format result |

## Verification
The paths that are hardest to reach are subnormal normalization and the narrowing limits. A load never produces a subnormal whose leading one sits deep in the fraction, and random doubles seldom have exponents near 874..896. The stimulus reaches these cases by patching zero and tiny register values with small immediates. It also draws patch register values with exponents chosen near each narrowing boundary and feeds earlier results back in as register values. Directed loads cover each named constant and the two-step +1.00390625 sequence.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam int SGL_EXP  = 8;
  localparam int SGL_FRAC = 23;
  localparam int DBL_EXP  = 11;
  localparam int DBL_FRAC = 52;
  localparam int SGL_W    = 1 + SGL_EXP + SGL_FRAC;
  localparam int DBL_W    = 1 + DBL_EXP + DBL_FRAC;
  localparam int IMM_W    = 16;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_PATCH = 1'b1
  } fimm_op_e;
endpackage

// File: rtl/fimm_imm_join.sv
module fimm_imm_join #(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1,
  localparam int IMM_W = HI_W + MID_W + LO_W
) (
  input  logic [HI_W-1:0]  fld_hi,
  input  logic [MID_W-1:0] fld_mid,
  input  logic [LO_W-1:0]  fld_lo,
  output logic [IMM_W-1:0] imm
);
  assign imm = {fld_hi, fld_mid, fld_lo};
endmodule

// File: rtl/fimm_narrow.sv
module fimm_narrow #(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52,
  localparam int SW = 1 + SE + SF,
  localparam int DW = 1 + DE + DF
) (
  input  logic [DW-1:0] d_in,
  output logic [SW-1:0] s_out
);
  localparam int BIAS_DIFF = (2**(DE-1) - 1) - (2**(SE-1) - 1);
  localparam int MAX_EXP   = BIAS_DIFF + 2**SE - 2;
  localparam int MIN_NORM  = BIAS_DIFF + 1;
  localparam int MIN_SUB   = MIN_NORM - SF;

  logic          sgn;
  logic [DE-1:0] dexp;
  logic [SF-1:0] top;
  logic [DE-1:0] shamt;
  logic [SF:0]   mant;
  logic [SE-1:0] rebiased;

  assign sgn      = d_in[DW-1];
  assign dexp     = d_in[DF +: DE];
  assign top      = d_in[DF-1 -: SF];
  assign shamt    = DE'(MIN_NORM) - dexp;
  assign mant     = {1'b1, top} >> shamt;
  assign rebiased = SE'(dexp - DE'(BIAS_DIFF));

  always_comb begin
    if (dexp == '0) begin
      s_out = {sgn, {(SW-1){1'b0}}};
    end else if (dexp == '1) begin
      s_out = {sgn, {SE{1'b1}}, top};
    end else if (dexp > DE'(MAX_EXP)) begin
      s_out = {sgn, {SE{1'b1}}, {SF{1'b0}}};
    end else if (dexp >= DE'(MIN_NORM)) begin
      s_out = {sgn, rebiased, top};
    end else if (dexp >= DE'(MIN_SUB)) begin
      s_out = {sgn, {SE{1'b0}}, mant[SF-1:0]};
    end else begin
      s_out = {sgn, {(SW-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen #(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52,
  localparam int SW = 1 + SE + SF,
  localparam int DW = 1 + DE + DF,
  localparam int LZW = $clog2(SF + 1)
) (
  input  logic [SW-1:0] s_in,
  output logic [DW-1:0] d_out
);
  localparam int BIAS_DIFF = (2**(DE-1) - 1) - (2**(SE-1) - 1);

  logic          sgn;
  logic [SE-1:0] sexp;
  logic [SF-1:0] sfrac;
  logic [LZW-1:0] lz;
  logic [SF-1:0] normed;

  assign sgn   = s_in[SW-1];
  assign sexp  = s_in[SF +: SE];
  assign sfrac = s_in[SF-1:0];

  // leading-zero count: the highest set bit wins
  always_comb begin
    lz = '0;
    for (int i = 0; i < SF; i++) begin
      if (sfrac[i]) lz = LZW'(SF - 1 - i);
    end
  end

  assign normed = sfrac << (lz + 1'b1);

  always_comb begin
    if (sexp == '0 && sfrac == '0) begin
      d_out = {sgn, {(DW-1){1'b0}}};
    end else if (sexp == '1) begin
      d_out = {sgn, {DE{1'b1}}, sfrac, {(DF-SF){1'b0}}};
    end else if (sexp == '0) begin
      d_out = {sgn, DE'(BIAS_DIFF) - DE'(lz), normed, {(DF-SF){1'b0}}};
    end else begin
      d_out = {sgn, DE'(sexp) + DE'(BIAS_DIFF), sfrac, {(DF-SF){1'b0}}};
    end
  end
endmodule

// File: rtl/fimm_builder.sv
module fimm_builder #(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      op,
  input  logic [HI_W-1:0]           fld_hi,
  input  logic [MID_W-1:0]          fld_mid,
  input  logic [LO_W-1:0]           fld_lo,
  input  logic [fimm_pkg::DBL_W-1:0] reg_value,
  output logic                      out_valid,
  output logic [fimm_pkg::DBL_W-1:0] out_value
);
  import fimm_pkg::*;

  localparam int IW = HI_W + MID_W + LO_W;
  localparam logic [SGL_W-1:0] LOW_MASK = SGL_W'((1 << IW) - 1);

  logic [IW-1:0]    imm;
  logic [SGL_W-1:0] narrowed;
  logic [SGL_W-1:0] patched;
  logic [SGL_W-1:0] single_sel;
  logic [DBL_W-1:0] widened;
  fimm_op_e         op_e;

  assign op_e = fimm_op_e'(op);

  fimm_imm_join #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_join (
    .fld_hi (fld_hi),
    .fld_mid(fld_mid),
    .fld_lo (fld_lo),
    .imm    (imm)
  );

  fimm_narrow #(.SE(SGL_EXP), .SF(SGL_FRAC), .DE(DBL_EXP), .DF(DBL_FRAC)) u_narrow (
    .d_in (reg_value),
    .s_out(narrowed)
  );

  assign patched    = (narrowed & ~LOW_MASK) | SGL_W'(imm);
  assign single_sel = (op_e == OP_PATCH) ? patched : {imm, {(SGL_W-IW){1'b0}}};

  fimm_widen #(.SE(SGL_EXP), .SF(SGL_FRAC), .DE(DBL_EXP), .DF(DBL_FRAC)) u_widen (
    .s_in (single_sel),
    .d_out(widened)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_value <= widened;
    end
  end
endmodule

// File: rtl/fimm_builder_chk.sv
module fimm_builder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        op,
  input logic [9:0]  fld_hi,
  input logic [4:0]  fld_mid,
  input logic [0:0]  fld_lo,
  input logic [63:0] reg_value,
  input logic        out_valid,
  input logic [63:0] out_value
);
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_value));
  assert_load_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op) |=> out_value[44:0] == 45'd0);
  assert_load_sign_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op) |=> out_value[63] == $past(fld_hi[9]));
  assert_load_special_exp_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op && fld_hi[8:1] == 8'hFF) |=> out_value[62:52] == 11'h7FF);
  assert_patch_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op) |=> out_value[63] == $past(reg_value[63]));
endmodule

bind fimm_builder fimm_builder_chk i_chk (.*);

// File: tb/test_fimm_builder.sv
`timescale 1ns/1ps
module test_fimm_builder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        op;
  logic [9:0]  fld_hi;
  logic [4:0]  fld_mid;
  logic [0:0]  fld_lo;
  logic [63:0] reg_value;
  logic        out_valid;
  logic [63:0] out_value;

  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] last_out = '0;

  always #4 clk = ~clk;

  fimm_builder i_fimm_builder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .fld_hi(fld_hi), .fld_mid(fld_mid), .fld_lo(fld_lo),
    .reg_value(reg_value), .out_valid(out_valid), .out_value(out_value)
  );

  function automatic logic [63:0] widen_m(logic [31:0] s);
    logic [23:0] m;
    int ex;
    if (s[30:23] == 8'h00 && s[22:0] == 23'd0) return {s[31], 63'd0};
    if (s[30:23] == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'd0};
    if (s[30:23] == 8'h00) begin
      m = {1'b0, s[22:0]};
      ex = 897;
      while (!m[23]) begin
        m = m << 1;
        ex = ex - 1;
      end
      return {s[31], ex[10:0], m[22:0], 29'd0};
    end
    ex = int'(s[30:23]) + 1023 - 127;
    return {s[31], ex[10:0], s[22:0], 29'd0};
  endfunction

  function automatic logic [31:0] narrow_m(logic [63:0] d);
    int ex;
    int sh;
    logic [23:0] m;
    ex = int'(d[62:52]);
    if (ex == 0) return {d[63], 31'd0};
    if (ex == 2047) return {d[63], 8'hFF, d[51:29]};
    if (ex - 896 >= 255) return {d[63], 8'hFF, 23'd0};
    if (ex - 896 >= 1) return {d[63], 8'(ex - 896), d[51:29]};
    sh = 897 - ex;
    if (sh > 23) return {d[63], 31'd0};
    m = {1'b1, d[51:29]} >> sh;
    return {d[63], 8'h00, m[22:0]};
  endfunction

  function automatic logic [63:0] expect_m(bit o, logic [15:0] imm, logic [63:0] rv);
    logic [31:0] n;
    if (!o) return widen_m({imm, 16'h0000});
    n = narrow_m(rv);
    return widen_m({n[31:16], imm});
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run(bit o, logic [15:0] imm, logic [63:0] rv, logic [63:0] exp, string req);
    in_valid  = 1'b1;
    op        = o;
    fld_hi    = imm[15:6];
    fld_mid   = imm[5:1];
    fld_lo    = imm[0];
    reg_value = rv;
    @(negedge clk);
    check(out_valid === 1'b1 && out_value === exp, req, out_value, exp);
    last_out = out_value;
    in_valid = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    n_fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; in_valid = 1'b0; op = 1'b0;
    fld_hi = '0; fld_mid = '0; fld_lo = '0; reg_value = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_value === 64'd0, "R9 reset", out_value, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R3 named constants (R1 field order exercised through imm split)
    run(0, 16'h0000, 64'h0, 64'h0000000000000000, "R3 +0");
    run(0, 16'h8000, 64'h0, 64'h8000000000000000, "R3 -0");
    run(0, 16'h3F80, 64'h0, 64'h3FF0000000000000, "R3 +1");
    run(0, 16'hBF80, 64'h0, 64'hBFF0000000000000, "R3 -1");
    run(0, 16'hBFC0, 64'h0, 64'hBFF8000000000000, "R3 -1.5");
    run(0, 16'h7FC0, 64'h0, 64'h7FF8000000000000, "R3 qNaN");
    run(0, 16'h7F80, 64'h0, 64'h7FF0000000000000, "R3 +inf R4");
    run(0, 16'hFF80, 64'h0, 64'hFFF0000000000000, "R3 -inf R4");
    run(0, 16'h3FFF, 64'h0, 64'h3FFFE00000000000, "R3 R1 1.9921875");
    // R6 two-step sequence using the previous result as register value
    run(0, 16'h3F80, 64'hDEAD_BEEF_0123_4567, 64'h3FF0000000000000, "R10 load ignores reg");
    run(1, 16'h8000, last_out, 64'h3FF0100000000000, "R6 patch");
    // R5 subnormal normalization
    run(1, 16'h0001, 64'h0, 64'h36A0000000000000, "R5 patch zero");
    run(0, 16'h0040, 64'h0, 64'h3800000000000000, "R5 load subnormal");
    run(1, 16'h0100, 64'h8000000000000000, expect_m(1, 16'h0100, 64'h8000000000000000), "R5 neg subnormal");
    // R7 narrowing limits
    run(1, 16'h0005, 64'h7FE0000000000000, 64'h7FF00000A0000000, "R7 overflow to inf");
    run(1, 16'h0000, 64'h0010000000000000, 64'h0000000000000000, "R7 underflow to zero");
    run(1, 16'h1234, 64'h3690000000000000, expect_m(1, 16'h1234, 64'h3690000000000000), "R7 below subnormal");
    run(1, 16'h0000, 64'h3800000000000000, 64'h3800000000000000, "R7 exp 896 subnormal");
    run(1, 16'hFFFF, 64'h47EFFFFFFFFFFFFF, expect_m(1, 16'hFFFF, 64'h47EFFFFFFFFFFFFF), "R7 top normal");

    // R8 hold during idle
    begin
      logic [63:0] held;
      held = out_value;
      @(negedge clk);
      check(out_valid === 1'b0, "R8 idle strobe", {63'd0, out_valid}, 64'd0);
      check(out_value === held, "R8 idle hold", out_value, held);
    end

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      bit o;
      logic [15:0] imm;
      logic [63:0] rv;
      int pick;
      o = 1'($urandom());
      imm = 16'($urandom());
      pick = int'($urandom() % 4);
      case (pick)
        0: rv = {$urandom(), $urandom()};
        1: rv = last_out;
        2: rv = {1'($urandom()), 11'(860 + ($urandom() % 50)), 52'({$urandom(), $urandom()})};
        default: rv = {1'($urandom()), 11'(1140 + ($urandom() % 20)), 52'({$urandom(), $urandom()})};
      endcase
      run(o, imm, rv, expect_m(o, imm, rv), o ? "R6 R7 random patch" : "R2 R10 random load");
      if ($urandom() % 8 == 0) begin
        logic [63:0] held;
        held = out_value;
        @(negedge clk);
        check(out_valid === 1'b0 && out_value === held, "R8 random idle", out_value, held);
      end
    end

    // reset again clears
    rst = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_value === 64'd0, "R9 reset again", out_value, 64'd0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule